// File: doc/BRIEF.md
# Serial front end for a two-channel successive-approximation converter

This block is the device-side digital interface of a two-input, 10-bit successive-approximation converter. A host addresses it with an active-low select, a serial clock and a data line. Once selected, the block skips any leading zeros and takes the first high data bit as the start marker. It then reads three configuration bits, raises a sample strobe and a convert strobe at the right serial edges, and shifts the result out on the data line. A low null bit comes first. An optional least-significant-first replay follows the main word, and after that the line carries zeros until the host deselects.

The analog levels reach the block as digital words, one per input, from a behavioural model. The block turns them into a code, either for one input on its own or for the two inputs taken as a pseudo-differential pair. Every serial input is first brought into the block clock domain through a synchronizer whose depth is a parameter. Serial edges are detected as events in that domain. The data output comes with a separate drive-enable, which models the tri-state pin.

Top module: `sar_serial_front`

## Requirements
- R1: A transfer is accepted only after a high-to-low transition of `cs_n` is observed. If `cs_n` is already low when reset ends, no start bit is taken and `sdo_oe` and `sample_o` stay 0 until `cs_n` has gone high and low again.
- R2: While selected, rising serial edges that see `din` low before the start are ignored. The first rising edge with `din` high is the start bit, and `sdo_oe` stays 0 until the null bit is driven.
- R3: The three rising edges after the start bit capture, in this order: the mode bit (1 = single-ended, 0 = pseudo-differential), the swap bit, and the order bit (1 = most-significant-first only).
- R4: `sample_o` is 1 from the second rising edge after the start bit to the falling edge of the third clock after it. `convert_o` is 1 from that same falling edge until the falling edge that drives result bit 0. The two strobes are never 1 together.
- R5: On the falling edge of the clock that carries the order bit, `sdo` is driven low (the null bit). The next ten falling edges drive result bits 9 down to 0.
- R6: `sdo` changes only on falling serial edges. `sdo_oe` is 0 while `cs_n` is high.
- R7: With the order bit at 1, every falling edge after bit 0 drives `sdo` low for as long as `cs_n` stays low.
- R8: With the order bit at 0, the falling edges after bit 0 drive bits 1 up to 9, so bit 0 is not repeated. After that they drive zeros.
- R9: `cs_n` going high at any point aborts the transfer. `sdo_oe`, `sample_o` and `convert_o` fall to 0, and the next transfer starts from idle.
- R10: In pseudo-differential mode the code is 0 when the positive input is at or below the negative input, and positive minus negative otherwise. It is capped at 3FFh.
- R11: In single-ended mode, swap bit 0 selects `ch0_level` and swap bit 1 selects `ch1_level`. In pseudo-differential mode, swap bit 0 makes `ch0_level` the positive input and swap bit 1 makes `ch1_level` the positive input.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock, much faster than the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low select from the host |
| sclk | input | 1 | Serial clock from the host |
| din | input | 1 | Serial data from the host |
| ch0_level | input | CODE_W | Digital level of input 0 |
| ch1_level | input | CODE_W | Digital level of input 1 |
| sdo | output | 1 | Serial result data |
| sdo_oe | output | 1 | Drive enable for `sdo` (0 = high impedance) |
| sample_o | output | 1 | Sample-window strobe |
| convert_o | output | 1 | Conversion strobe |

## Verification
One falling serial edge does three things at once: it closes the sample window, opens the conversion strobe and drives the null bit. A second overlap is the abort. A rising select can land in the configuration phase, inside the main word or inside the replay. The bench reads the strobes and the data line after every falling edge around the order-bit clock. It also cuts transfers at random clock counts and then checks that the drive-enable and both strobes are low before the next transfer. That next transfer must decode correctly, which shows the block really went back to idle.

// File: rtl/sar_fe_pkg.sv
package sar_fe_pkg;

   typedef enum logic [1:0] {
      FE_IDLE = 2'd0,
      FE_HUNT = 2'd1,
      FE_CFG  = 2'd2,
      FE_XFER = 2'd3
   } fe_state_t;

endpackage

// File: rtl/sar_fe_sync.sv
module sar_fe_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cs_n_i,
   input  logic sclk_i,
   input  logic din_i,
   output logic cs_n_o,
   output logic din_o,
   output logic rise_o,
   output logic fall_o,
   output logic cs_fall_o
);

   logic [2:0] raw;
   logic [2:0] synced;
   logic       sclk_prev;
   logic       cs_prev;

   assign raw = {cs_n_i, sclk_i, din_i};

   generate
      if (STAGES == 0) begin : g_direct
         assign synced = raw;
      end else begin : g_chain
         logic [2:0] stg [STAGES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < STAGES; i++) stg[i] <= '0;
            end else begin
               stg[0] <= raw;
               for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
            end
         end
         assign synced = stg[STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_prev <= 1'b0;
         cs_prev   <= 1'b0;
      end else begin
         sclk_prev <= synced[1];
         cs_prev   <= synced[2];
      end
   end

   assign cs_n_o    = synced[2];
   assign din_o     = synced[0];
   assign rise_o    = synced[1] & ~sclk_prev;
   assign fall_o    = ~synced[1] & sclk_prev;
   assign cs_fall_o = ~synced[2] & cs_prev;

endmodule

// File: rtl/sar_fe_code.sv
module sar_fe_code #(
   parameter int CODE_W = 10
) (
   input  logic              single_i,
   input  logic              swap_i,
   input  logic [CODE_W-1:0] ch0_i,
   input  logic [CODE_W-1:0] ch1_i,
   output logic [CODE_W-1:0] code_o
);

   logic [CODE_W-1:0] pos;
   logic [CODE_W-1:0] neg;
   logic [CODE_W:0]   diff;

   assign pos  = swap_i ? ch1_i : ch0_i;
   assign neg  = swap_i ? ch0_i : ch1_i;
   assign diff = {1'b0, pos} - {1'b0, neg};

   always_comb begin
      if (single_i)        code_o = pos;
      else if (pos <= neg) code_o = '0;
      else                 code_o = diff[CODE_W-1:0];
   end

   always_comb begin
      if (!single_i) begin
         AST_DIFF_BOUND: assert (code_o <= pos); // R10
      end
   end

endmodule

// File: rtl/sar_fe_shift.sv
module sar_fe_shift #(
   parameter int CODE_W = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              abort_i,
   input  logic              arm_i,
   input  logic              msb_only_i,
   input  logic              fall_i,
   input  logic [CODE_W-1:0] code_i,
   output logic              sdo_o,
   output logic              oe_o,
   output logic              convert_o
);

   localparam int CNT_W = $clog2(2 * CODE_W + 1);
   localparam int IDX_W = $clog2(CODE_W);
   localparam logic [CNT_W-1:0] POS_LAST = CNT_W'(2 * CODE_W);
   localparam logic [CNT_W-1:0] POS_B0   = CNT_W'(CODE_W);
   localparam logic [CNT_W-1:0] POS_REND = CNT_W'(2 * CODE_W - 1);

   logic              run;
   logic              msb_only_q;
   logic [CNT_W-1:0]  fcnt;
   logic [CODE_W-1:0] result;
   logic              nxt_bit;
   logic [IDX_W-1:0]  idx;

   always_comb begin
      nxt_bit = 1'b0;
      idx     = '0;
      if (fcnt != '0 && fcnt <= POS_B0) begin
         idx     = IDX_W'(CODE_W - int'(fcnt));
         nxt_bit = result[idx];
      end else if (!msb_only_q && fcnt > POS_B0 && fcnt <= POS_REND) begin
         idx     = IDX_W'(int'(fcnt) - CODE_W);
         nxt_bit = result[idx];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run        <= 1'b0;
         msb_only_q <= 1'b0;
         fcnt       <= '0;
         result     <= '0;
         sdo_o      <= 1'b0;
         oe_o       <= 1'b0;
         convert_o  <= 1'b0;
      end else if (abort_i) begin
         run       <= 1'b0;
         fcnt      <= '0;
         sdo_o     <= 1'b0;
         oe_o      <= 1'b0;
         convert_o <= 1'b0;
      end else if (arm_i) begin
         run        <= 1'b1;
         fcnt       <= '0;
         msb_only_q <= msb_only_i;
      end else if (run && fall_i) begin
         oe_o <= 1'b1;
         if (fcnt != POS_LAST) fcnt <= fcnt + 1'b1;
         if (fcnt == '0) begin
            result    <= code_i;
            sdo_o     <= 1'b0;
            convert_o <= 1'b1;
         end else begin
            sdo_o <= nxt_bit;
            if (fcnt == POS_B0) convert_o <= 1'b0;
         end
      end
   end

   AST_NULL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (run && fall_i && !abort_i && !arm_i && fcnt == '0) |=> (oe_o && !sdo_o)); // R5
   AST_SDO_FALL_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      (!fall_i && !abort_i) |=> $stable(sdo_o)); // R6

endmodule

// File: rtl/sar_serial_front.sv
module sar_serial_front #(
   parameter int CODE_W      = 10,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_n,
   input  logic              sclk,
   input  logic              din,
   input  logic [CODE_W-1:0] ch0_level,
   input  logic [CODE_W-1:0] ch1_level,
   output logic              sdo,
   output logic              sdo_oe,
   output logic              sample_o,
   output logic              convert_o
);
   import sar_fe_pkg::*;

   generate
      if (CODE_W < 2 || CODE_W > 16) begin : g_bad_width
         $error("CODE_W must lie between 2 and 16");
      end
      if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("SYNC_STAGES must lie between 0 and 4");
      end
   endgenerate

   fe_state_t         state;
   logic [1:0]        rcnt;
   logic              single_q;
   logic              swap_q;
   logic              msb_only_q;
   logic              arm;
   logic              sample_q;
   logic              cs_n_s;
   logic              din_s;
   logic              rise_ev;
   logic              fall_ev;
   logic              cs_fall_ev;
   logic [CODE_W-1:0] code;

   sar_fe_sync #(.STAGES(SYNC_STAGES)) i_sync (
      .clk       (clk),
      .rst_n     (rst_n),
      .cs_n_i    (cs_n),
      .sclk_i    (sclk),
      .din_i     (din),
      .cs_n_o    (cs_n_s),
      .din_o     (din_s),
      .rise_o    (rise_ev),
      .fall_o    (fall_ev),
      .cs_fall_o (cs_fall_ev)
   );

   sar_fe_code #(.CODE_W(CODE_W)) i_code (
      .single_i (single_q),
      .swap_i   (swap_q),
      .ch0_i    (ch0_level),
      .ch1_i    (ch1_level),
      .code_o   (code)
   );

   sar_fe_shift #(.CODE_W(CODE_W)) i_shift (
      .clk        (clk),
      .rst_n      (rst_n),
      .abort_i    (cs_n_s),
      .arm_i      (arm),
      .msb_only_i (msb_only_q),
      .fall_i     (fall_ev),
      .code_i     (code),
      .sdo_o      (sdo),
      .oe_o       (sdo_oe),
      .convert_o  (convert_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= FE_IDLE;
         rcnt       <= '0;
         single_q   <= 1'b0;
         swap_q     <= 1'b0;
         msb_only_q <= 1'b0;
         arm        <= 1'b0;
         sample_q   <= 1'b0;
      end else begin
         arm <= 1'b0;
         if (cs_n_s) begin
            state    <= FE_IDLE;
            rcnt     <= '0;
            sample_q <= 1'b0;
         end else begin
            unique case (state)
               FE_IDLE: if (cs_fall_ev) state <= FE_HUNT;
               FE_HUNT: if (rise_ev && din_s) begin
                  state <= FE_CFG;
                  rcnt  <= '0;
               end
               FE_CFG: if (rise_ev) begin
                  rcnt <= rcnt + 2'd1;
                  case (rcnt)
                     2'd0: single_q <= din_s;
                     2'd1: begin
                        swap_q   <= din_s;
                        sample_q <= 1'b1;
                     end
                     default: begin
                        msb_only_q <= din_s;
                        arm        <= 1'b1;
                        state      <= FE_XFER;
                     end
                  endcase
               end
               FE_XFER: if (fall_ev) sample_q <= 1'b0;
               default: state <= FE_IDLE;
            endcase
         end
      end
   end

   assign sample_o = sample_q;

   AST_QUIET_BEFORE_NULL: assert property (@(posedge clk) disable iff (!rst_n)
      (state != FE_XFER) |-> !sdo_oe); // R2
   AST_DESELECT_HIGHZ: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n_s |=> (!sdo_oe && !sample_o && !convert_o)); // R9
   AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(sample_o && convert_o)); // R4

endmodule

// File: tb/test_sar_serial_front.sv
`timescale 1ns/1ps
module test_sar_serial_front;
   localparam int W    = 10;
   localparam int HALF = 8;
   localparam int SAMP = 6;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         cs_n = 1'b0;
   logic         sclk = 1'b0;
   logic         din = 1'b0;
   logic [W-1:0] ch0 = '0;
   logic [W-1:0] ch1 = '0;
   logic         sdo, sdo_oe, sample_o, convert_o;
   int           n_chk = 0;
   int           n_err = 0;

   always #2.5 clk = ~clk;

   sar_serial_front #(.CODE_W(W), .SYNC_STAGES(2)) i_sar_serial_front (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .din(din),
      .ch0_level(ch0), .ch1_level(ch1),
      .sdo(sdo), .sdo_oe(sdo_oe), .sample_o(sample_o), .convert_o(convert_o));

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wclk(input int n);
      repeat (n) @(negedge clk);
   endtask

   function automatic logic [W-1:0] exp_code(input bit sgl, input bit swp,
                                             input logic [W-1:0] a, input logic [W-1:0] b);
      logic [W-1:0] p, n;
      p = swp ? b : a;
      n = swp ? a : b;
      if (sgl) return p;
      if (p <= n) return '0;
      return p - n;
   endfunction

   function automatic bit exp_bit(input int p, input bit msbf, input logic [W-1:0] c);
      if (p == 0) return 1'b0;
      if (p <= W) return c[W-p];
      if (!msbf && p <= 2*W-1) return c[p-W];
      return 1'b0;
   endfunction

   task automatic txn(input int lead, input bit sgl, input bit swp, input bit msbf,
                      input int nclk, input logic [W-1:0] a, input logic [W-1:0] b);
      logic [W-1:0] c;
      bit last;
      string tag;
      c    = exp_code(sgl, swp, a, b);
      last = 1'b0;
      ch0  = a;
      ch1  = b;
      cs_n = 1'b0;
      wclk(HALF);
      for (int k = 0; k < lead; k++) begin
         din = 1'b0;
         wclk(HALF); sclk = 1'b1; wclk(HALF); sclk = 1'b0; wclk(SAMP);
         chk("R2 leading zero keeps sdo_oe low", sdo_oe, 0);
         chk("R2 leading zero no sample", sample_o, 0);
         wclk(HALF - SAMP);
      end
      for (int j = 0; j < nclk; j++) begin
         din = (j == 0) ? 1'b1 : (j == 1) ? sgl : (j == 2) ? swp : (j == 3) ? msbf
               : 1'($urandom % 2);
         wclk(HALF);
         sclk = 1'b1;
         wclk(SAMP);
         if (j == 2) chk("R4 sample opens on second rise", sample_o, 1);
         if (j >= 4) chk("R6 sdo steady across rise", sdo, last);
         wclk(HALF - SAMP);
         sclk = 1'b0;
         wclk(SAMP);
         if (j < 3) begin
            chk("R2 sdo_oe low before null", sdo_oe, 0);
         end else begin
            int p;
            p = j - 3;
            if (p <= W) tag = "R5 R3 R10 R11 word bit";
            else if (!msbf && p <= 2*W-1) tag = "R8 replay bit";
            else tag = (msbf) ? "R7 trailing zero" : "R8 trailing zero";
            chk(tag, sdo, exp_bit(p, msbf, c));
            chk("R6 sdo_oe driven after null", sdo_oe, 1);
            last = sdo;
         end
         chk("R4 sample window", sample_o, (j == 2) ? 1 : 0);
         chk("R4 convert window", convert_o, (j >= 3 && j <= 3 + W - 1) ? 1 : 0);
         wclk(HALF - SAMP);
      end
      cs_n = 1'b1;
      wclk(SAMP);
      chk("R9 R6 deselect tri-states", sdo_oe, 0);
      chk("R9 deselect clears sample", sample_o, 0);
      chk("R9 deselect clears convert", convert_o, 0);
      wclk(HALF);
   endtask

   initial begin
      void'($urandom(32'd7011));
      cs_n = 1'b0;
      wclk(4);
      rst_n = 1'b1;
      wclk(4);
      chk("R6 reset sdo_oe", sdo_oe, 0);
      chk("R4 reset sample", sample_o, 0);
      chk("R4 reset convert", convert_o, 0);
      chk("R5 reset sdo", sdo, 0);

      // R1: select already low at reset, clocks with din high must be ignored
      for (int k = 0; k < 8; k++) begin
         din = 1'b1;
         wclk(HALF); sclk = 1'b1; wclk(HALF); sclk = 1'b0; wclk(SAMP);
         chk("R1 no transfer without select edge (oe)", sdo_oe, 0);
         chk("R1 no transfer without select edge (sample)", sample_o, 0);
         wclk(HALF - SAMP);
      end
      cs_n = 1'b1;
      wclk(2 * HALF);

      txn(0, 1'b1, 1'b0, 1'b1, 20, 10'h2A5, 10'h1C3);
      txn(3, 1'b1, 1'b1, 1'b0, 28, 10'h0F0, 10'h35A);
      txn(1, 1'b1, 1'b0, 1'b0, 26, 10'h201, 10'h000);
      txn(0, 1'b0, 1'b0, 1'b1, 14, 10'h300, 10'h100);
      txn(2, 1'b0, 1'b1, 1'b1, 14, 10'h100, 10'h300);
      txn(0, 1'b0, 1'b0, 1'b1, 14, 10'h155, 10'h155);
      txn(0, 1'b0, 1'b0, 1'b0, 24, 10'h0FF, 10'h200);
      txn(0, 1'b0, 1'b0, 1'b1, 14, 10'h3FF, 10'h000);
      txn(1, 1'b1, 1'b0, 1'b0, 2, 10'h3FF, 10'h3FF);
      txn(0, 1'b1, 1'b1, 1'b1, 7, 10'h2AA, 10'h155);
      txn(0, 1'b1, 1'b1, 1'b0, 17, 10'h3C3, 10'h155);
      for (int t = 0; t < 25; t++) begin
         txn(int'($urandom % 6), 1'($urandom % 2), 1'($urandom % 2), 1'($urandom % 2),
             1 + int'($urandom % 28), W'($urandom), W'($urandom));
      end
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_err++;
      n_chk++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule